// File: doc/BRIEF.md
# Configurable Byte Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock (SCK), a serial input (SI) and a serial output (SO). Software programs a mode register that chooses the shift-clock source, the bit order, and whether the port transmits while it receives. The shift clock can come from an internal divider, from the link partner through the SCK pin, or from a tick produced by a companion timer. Writing the data buffer starts a transfer. After eight SCK rising edges the port stops, pulses an interrupt request for one cycle and leaves the received byte in the data buffer.

SO changes only after a falling SCK edge, so it is stable at the next rising edge, where SI is sampled. When this block generates SCK, it drives the pin and holds it high between transfers. When SCK comes from outside, the pin is an input. Both SCK and SI then pass through a synchroniser before edge detection. In receive-only mode SO holds its level while incoming bits still fill the buffer.

Top module: `sio_port`

## Requirements
- R1: After reset, sck_out=1, sck_oe=1, so=1, irq=0, and the mode register reads 0x00.
- R2: The mode register at reg_sel=0 holds these fields: bit0 tx_en (1 = transmit-and-receive, 0 = receive-only), bit1 lsb_first, bits3:2 clock source (0 internal, 1 external pin, 2 timer tick, 3 off), and bits6:4 divider. Bit7 always reads 0.
- R3: A data write (reg_sel=1) while idle, with a source other than off, starts a transfer of exactly 8 bits. After the 8th rising edge, irq is high for exactly one cycle and reg_rdata at reg_sel=1 returns the received byte.
- R4: With lsb_first=0, SO presents the buffer bits from bit7 down to bit0, and received bits enter at bit0 and move toward bit7.
- R5: With lsb_first=1, SO presents the buffer bits from bit0 up to bit7, and received bits enter at bit7 and move toward bit0.
- R6: With the internal source, SCK is driven (sck_oe=1) and idles high. Each SCK phase lasts div+1 clock cycles. irq appears 16*(div+1) cycles after the write edge, and SCK is low for 8*(div+1) of those cycles.
- R7: With the timer source, each tmr_tick during a transfer toggles SCK, and irq follows the 16th tick. Ticks while idle leave SCK high and raise no irq.
- R8: With the external source, sck_oe=0. SCK and SI are synchronised, SI is sampled on the detected rising edge, and SO updates after the detected falling edge.
- R9: In receive-only mode, SO keeps its level during the whole transfer while the buffer still collects SI.
- R10: During a transfer, writes to the data buffer and to the mode register are ignored.
- R11: With the source set to off, a data write loads the buffer, which reads back unchanged, and starts no transfer.
- R12: A data write in the same cycle as the 8th rising edge is ignored. The received byte is kept and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 data buffer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| sck_in | input | 1 | SCK pin level when an external source drives it |
| sck_out | output | 1 | SCK level driven by the port |
| sck_oe | output | 1 | SCK output enable, low for the external source |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| tmr_tick | input | 1 | Single-cycle tick from the companion timer |
| irq | output | 1 | Single-cycle transfer-complete request |

## Verification
A register write can arrive in the same cycle as the final rising shift edge, which ends the transfer. The bench provokes this with the internal source at divider 0, where the 8th rising edge lands exactly 16 cycles after the starting write, and places a second data write on that edge. The outcome is judged from the ports: irq pulses exactly once, the buffer still reads the byte that came in over SI, and no further SCK activity or irq follows.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DIV_W = 3;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_TMR = 2'd2,
    SRC_OFF = 2'd3
  } sck_src_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    sck_src_e         src;
    logic             lsb_first;
    logic             tx_en;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = d;
    end else begin : g_many
      always_comb chain_n = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sio_edge_gen.sv
module sio_edge_gen
  import sio_pkg::*;
#(
  parameter int DW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  sck_src_e      src,
  input  logic [DW-1:0] div,
  input  logic          tmr_tick,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  output logic          rise,
  output logic          fall
);
  logic [DW-1:0] div_cnt_q, div_cnt_n;
  logic          sck_q, sck_n;
  logic          sck_s, sck_p_q;
  logic          tick, ext_rise, ext_fall;

  sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s)
  );

  always_comb begin
    tick = run && (((src == SRC_INT) && (div_cnt_q == div)) ||
                   ((src == SRC_TMR) && tmr_tick));
    if (!run || (src != SRC_INT) || (div_cnt_q == div)) div_cnt_n = '0;
    else                                                div_cnt_n = div_cnt_q + 1'b1;
    if (!run)      sck_n = 1'b1;
    else if (tick) sck_n = ~sck_q;
    else           sck_n = sck_q;
    ext_rise = run && (src == SRC_EXT) && sck_s && !sck_p_q;
    ext_fall = run && (src == SRC_EXT) && !sck_s && sck_p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      sck_q     <= 1'b1;
      sck_p_q   <= 1'b1;
    end else begin
      div_cnt_q <= div_cnt_n;
      sck_q     <= sck_n;
      sck_p_q   <= sck_s;
    end
  end

  assign rise    = (tick && !sck_q) || ext_rise;
  assign fall    = (tick && sck_q) || ext_fall;
  assign sck_out = sck_q;
  assign sck_oe  = (src != SRC_EXT);

  assert_sck_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sck_out) else $error("SCK not high while idle");
  assert_oe_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT) |-> !sck_oe) else $error("SCK driven in external mode");
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         rise,
  input  logic         fall,
  input  logic         si,
  input  logic         lsb_first,
  input  logic         tx_en,
  output logic [W-1:0] rx_data,
  output logic         busy,
  output logic         irq,
  output logic         so
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q, sr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          irq_q, irq_n;
  logic          so_q, so_n;

  always_comb begin
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    irq_n  = 1'b0;
    so_n   = so_q;
    if (!busy_q) begin
      if (start) begin
        sr_n   = wdata;
        cnt_n  = '0;
        busy_n = 1'b1;
      end else if (load) begin
        sr_n = wdata;
      end
    end else begin
      if (fall && tx_en) so_n = lsb_first ? sr_q[0] : sr_q[W-1];
      if (rise) begin
        sr_n  = lsb_first ? {si, sr_q[W-1:1]} : {sr_q[W-2:0], si};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          busy_n = 1'b0;
          irq_n  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      so_q   <= 1'b1;
    end else begin
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      irq_q  <= irq_n;
      so_q   <= so_n;
    end
  end

  assign rx_data = sr_q;
  assign busy    = busy_q;
  assign irq     = irq_q;
  assign so      = so_q;

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q) else $error("irq longer than one cycle");
  assert_end_with_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq_q) else $error("transfer ended without irq");
  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(W))) else $error("bit count past byte size");
  assert_rx_only_so_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tx_en) |=> $stable(so_q)) else $error("SO moved in receive-only mode");
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              si,
  output logic              so,
  input  logic              tmr_tick,
  output logic              irq
);
  mode_t             mode_q, mode_n;
  logic              busy;
  logic              wr_data, start, load;
  logic              rise, fall;
  logic              si_s, si_use;
  logic [DATA_W-1:0] rx_data;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:MODE_W];

  always_comb begin
    wr_data = reg_we && reg_sel;
    start   = wr_data && !busy && (mode_q.src != SRC_OFF);
    load    = wr_data && !busy && (mode_q.src == SRC_OFF);
    if (reg_we && !reg_sel && !busy) mode_n = mode_t'(reg_wdata[MODE_W-1:0]);
    else                             mode_n = mode_q;
    si_use  = (mode_q.src == SRC_EXT) ? si_s : si;
    reg_rdata = reg_sel ? rx_data : DATA_W'(mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_n;
  end

  sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync (
    .clk(clk), .rst_n(rst_n), .d(si), .q(si_s)
  );

  sio_edge_gen #(.DW(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(busy), .src(mode_q.src), .div(mode_q.div),
    .tmr_tick(tmr_tick), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .rise(rise), .fall(fall)
  );

  sio_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .load(load), .wdata(reg_wdata),
    .rise(rise), .fall(fall), .si(si_use), .lsb_first(mode_q.lsb_first),
    .tx_en(mode_q.tx_en), .rx_data(rx_data), .busy(busy), .irq(irq), .so(so)
  );

  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)) else $error("mode changed mid-transfer");
  assert_irq_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy) else $error("irq while still busy");
endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;
  logic       clk = 1'b0;
  logic       rst_n, reg_we, reg_sel, sck_in, tmr_tick, loop_en, tb_si;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sck_out, sck_oe, so, irq, si;
  int         errors = 0, checks = 0, irq_cnt = 0;

  always #4 clk = ~clk;
  assign si = loop_en ? so : tb_si;

  sio_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so),
    .tmr_tick(tmr_tick), .irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mode_byte(input logic [2:0] dv, input logic [1:0] src,
                                           input logic lsb, input logic tx);
    return {1'b0, dv, src, lsb, tx};
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // SO bits collected first-out at bit7 of the capture
  function automatic logic [7:0] wire_order(input logic [7:0] d, input logic lsb);
    return lsb ? rev8(d) : d;
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic run_int(input logic [7:0] d, input logic lsb, input logic [2:0] dv);
    int k, lows, base;
    logic prev, lastso;
    logic [7:0] cap, rb;
    loop_en = 1'b1;
    wr(1'b0, mode_byte(dv, 2'd0, lsb, 1'b1));
    base = irq_cnt; k = 0; lows = 0; prev = 1'b1; lastso = 1'b0; cap = 8'h00;
    wr(1'b1, d);
    while (!irq && k < 5000) begin
      @(negedge clk); k++;
      if (!sck_out) begin lows++; lastso = so; end
      if (sck_out && !prev) cap = {cap[6:0], lastso};
      prev = sck_out;
    end
    chk("R6 cycles write to irq", k, 16 * (int'(dv) + 1));
    chk("R6 SCK low cycles", lows, 8 * (int'(dv) + 1));
    chk(lsb ? "R5 SO order lsb-first" : "R4 SO order msb-first", cap, wire_order(d, lsb));
    @(negedge clk);
    chk("R3 irq single cycle", irq, 0);
    chk("R3 one irq per transfer", irq_cnt - base, 1);
    rd(1'b1, rb);
    chk("R3 loopback byte", rb, d);
  endtask

  task automatic run_tmr(input logic [7:0] d, input logic lsb);
    int base;
    logic lastso;
    logic [7:0] cap, rb;
    loop_en = 1'b1; cap = 8'h00; lastso = 1'b0;
    wr(1'b0, mode_byte(3'd0, 2'd2, lsb, 1'b1));
    base = irq_cnt;
    for (int i = 0; i < 3; i++) begin
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0; @(negedge clk);
    end
    chk("R7 idle ticks leave SCK high", sck_out, 1);
    chk("R7 idle ticks raise no irq", irq_cnt - base, 0);
    wr(1'b1, d);
    for (int i = 0; i < 16; i++) begin
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
      if (!sck_out) lastso = so;
      else cap = {cap[6:0], lastso};
      if (i == 15) chk("R7 irq after 16th tick", irq, 1);
      else if (irq) chk("R7 early irq", irq, 0);
      @(negedge clk); @(negedge clk);
    end
    chk("R7 one irq", irq_cnt - base, 1);
    chk(lsb ? "R5 timer order" : "R4 timer order", cap, wire_order(d, lsb));
    rd(1'b1, rb);
    chk("R7 timer loopback byte", rb, d);
  endtask

  task automatic run_ext(input logic [7:0] p, input logic lsb, input logic tx);
    int base;
    logic so0, so_moved;
    logic [7:0] cap, rb;
    loop_en = tx; cap = 8'h00; so_moved = 1'b0;
    wr(1'b0, mode_byte(3'd0, 2'd1, lsb, tx));
    chk("R8 SCK not driven", sck_oe, 0);
    base = irq_cnt;
    wr(1'b1, tx ? p : 8'h00);
    so0 = so;
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0;
      tb_si = lsb ? p[i] : p[7-i];
      repeat (5) @(negedge clk);
      cap = {cap[6:0], so};
      if (so != so0) so_moved = 1'b1;
      sck_in = 1'b1;
      repeat (5) @(negedge clk);
      if (so != so0) so_moved = 1'b1;
    end
    repeat (3) @(negedge clk);
    chk("R8 one irq external", irq_cnt - base, 1);
    rd(1'b1, rb);
    chk(tx ? "R8 external loopback byte" : "R9 received byte", rb, p);
    if (tx) chk(lsb ? "R5 external order" : "R4 external order", cap, wire_order(p, lsb));
    else    chk("R9 SO held", so_moved, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    int base;
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    sck_in = 1'b1; tmr_tick = 1'b0; loop_en = 1'b1; tb_si = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sck_out", sck_out, 1);
    chk("R1 sck_oe", sck_oe, 1);
    chk("R1 so", so, 1);
    chk("R1 irq", irq, 0);
    rd(1'b0, rb);
    chk("R1 mode", rb, 0);

    wr(1'b0, 8'hFF);
    rd(1'b0, rb);
    chk("R2 mode readback bit7 zero", rb, 8'h7F);

    // R11: source off loads the buffer only
    base = irq_cnt;
    wr(1'b1, 8'h5A);
    repeat (40) @(negedge clk);
    rd(1'b1, rb);
    chk("R11 buffer loaded", rb, 8'h5A);
    chk("R11 no transfer irq", irq_cnt - base, 0);
    chk("R11 SCK idle", sck_out, 1);

    run_int(8'hB4, 1'b0, 3'd0);
    run_int(8'hB4, 1'b1, 3'd2);
    for (int n = 0; n < 6; n++)
      run_int(8'($urandom), 1'($urandom), 3'($urandom_range(0, 3)));

    run_tmr(8'hC3, 1'b0);
    run_tmr(8'h1E, 1'b1);

    run_ext(8'h96, 1'b0, 1'b1);
    run_ext(8'h29, 1'b1, 1'b1);
    run_ext(8'hD1, 1'b0, 1'b0);
    run_ext(8'h3A, 1'b1, 1'b0);

    // R10: writes during a transfer are ignored
    loop_en = 1'b1;
    wr(1'b0, mode_byte(3'd3, 2'd0, 1'b0, 1'b1));
    base = irq_cnt;
    wr(1'b1, 8'h6D);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h00);
    wr(1'b0, mode_byte(3'd0, 2'd3, 1'b1, 1'b0));
    while (!irq) @(negedge clk);
    repeat (30) @(negedge clk);
    rd(1'b1, rb);
    chk("R10 data write ignored", rb, 8'h6D);
    rd(1'b0, rb);
    chk("R10 mode write ignored", rb, mode_byte(3'd3, 2'd0, 1'b0, 1'b1));
    chk("R10 single irq", irq_cnt - base, 1);

    // R12: data write on the 8th rising edge
    wr(1'b0, mode_byte(3'd0, 2'd0, 1'b1, 1'b1));
    base = irq_cnt;
    wr(1'b1, 8'hE7);
    repeat (15) @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h18;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R12 irq on final edge", irq, 1);
    repeat (40) @(negedge clk);
    chk("R12 no second transfer", irq_cnt - base, 1);
    chk("R12 SCK idle after", sck_out, 1);
    rd(1'b1, rb);
    chk("R12 received byte kept", rb, 8'hE7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule